// File: doc/BRIEF.md
# UART Channel Command and Mode Register Block

This block is the control register file of one UART channel. A host writes byte-wide values to three register addresses. The command address turns the receiver and transmitter on and off. In the same write it can issue a one-shot command. The mode address holds three mode registers. A pointer picks which one a write reaches. The pointer moves forward on each mode write, and two commands set it back. The status address returns a byte built from the live flags of the receiver and transmitter and from sticky error flags.

The shift registers and baud generator sit outside this block. The block gives them the decoded frame settings: data length, parity, stop bits, FIFO enable, TX threshold and baud set. It also gives them the enable levels and one-cycle reset strobes. In return, that logic supplies the ready, full and empty levels and one-cycle error events.

Address map: 0 selects the mode register at the pointer, 1 is status (a write there does nothing), 2 is the command register, and 3 reads as zero. Every write takes effect at the clock edge on which `wrEn` is high. Reads come from `rdData`, a combinational output with no side effects.

Top module: `uart_chan_ctrl`

## Requirements
- R1: After reset, both enables are low and the pointer selects the middle mode register. The frame settings read 8 data bits, no parity and one stop bit. FIFO is off, and the four sticky status bits are zero.
- R2: In a command write, bit 0 turns RX on, bit 1 turns RX off, bit 2 turns TX on and bit 3 turns TX off. The change is visible after the write's clock edge. These bits act together with the command code in bits [7:4] of the same write.
- R3: When the on and off bits of one direction are both set in a single write, that direction ends up off.
- R4: Command code 0x1 points at the middle mode register and code 0xB points at the first one. Each mode-address write stores into the register at the pointer. The pointer then moves first to middle to last.
- R5: Once the pointer reaches the last mode register, further mode writes keep landing there until a pointer command is issued.
- R6: In the middle mode register, bits [1:0] set the data length: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Bits [4:2] set the parity: 0 is even, 1 is odd and 4 is none.
- R7: In the last mode register, a low nibble of 0x7 gives one stop bit and 0xF gives two stop bits.
- R8: In the first mode register, bit 3 enables the FIFO, bit 4 selects the half-level TX threshold and bits [2:0] select the baud set.
- R9: The status byte holds, from bit 0 up: RX ready, RX full, TX ready, TX empty, overrun, parity error, framing error and received break. Bits 0 to 3 follow their inputs directly. Bits 4 to 7 are set by one-cycle event inputs and stay set.
- R10: Command code 0x4 clears all four sticky status bits at one edge. The clear wins over an event that arrives at that same edge.
- R11: Command code 0x2 gives a one-cycle RX reset strobe and turns RX off. Code 0x3 does the same for TX. Each wins over an on bit in the same write.
- R12: Command code 0x6 raises the break output and code 0x7 lowers it. Code 0x5 gives a one-cycle break-change clear strobe.
- R13: Reading address 0 returns the mode register at the pointer and reading address 1 returns the status byte. Reads change nothing. A write to the status address leaves all settings and flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| regAddr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| rxReady | input | 1 | Receiver holds a character |
| rxFull | input | 1 | Receiver FIFO is full |
| txReady | input | 1 | Transmitter can accept a character |
| txEmpty | input | 1 | Transmitter is fully idle |
| ovrEvt | input | 1 | Overrun event pulse |
| parEvt | input | 1 | Parity error event pulse |
| frmEvt | input | 1 | Framing error event pulse |
| brkEvt | input | 1 | Received break event pulse |
| rxEnable | output | 1 | Receiver enable level |
| txEnable | output | 1 | Transmitter enable level |
| rxResetPulse | output | 1 | One-cycle receiver reset strobe |
| txResetPulse | output | 1 | One-cycle transmitter reset strobe |
| brkChgClr | output | 1 | One-cycle break-change clear strobe |
| breakOn | output | 1 | Drive a break on the line |
| dataBits | output | 4 | Data bits per character (5 to 8) |
| parityOn | output | 1 | Parity is generated and checked |
| parityOdd | output | 1 | Odd parity is selected (only while parityOn is high) |
| twoStop | output | 1 | Two stop bits are selected |
| fifoEn | output | 1 | FIFO is enabled |
| txHalfLevel | output | 1 | Half-level TX threshold is selected |
| baudSet | output | 3 | Baud set select |
| statusByte | output | 8 | Assembled status byte |

## Verification
The bench builds the block with its default mode-register reset values (0x00, 0x13, 0x07). This makes the reset frame settings a known reference point, so the bench can show that each write really changed them. With these values, the walk through the pointer order shows which register each write landed in: first to middle to last, then staying on the last. It also brings within reach the case where a clear and an error event meet at the same edge.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;
  typedef enum logic [1:0] {
    PTR_MR0 = 2'd0,
    PTR_MR1 = 2'd1,
    PTR_MR2 = 2'd2
  } modePtr_e;

  localparam int ADDR_W = 2;
  localparam int BUS_W  = 8;
  localparam int NUM_MR = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd2;

  localparam logic [3:0] CMD_PTR1   = 4'h1;
  localparam logic [3:0] CMD_RXRST  = 4'h2;
  localparam logic [3:0] CMD_TXRST  = 4'h3;
  localparam logic [3:0] CMD_ERRRST = 4'h4;
  localparam logic [3:0] CMD_BRKCHG = 4'h5;
  localparam logic [3:0] CMD_BRKON  = 4'h6;
  localparam logic [3:0] CMD_BRKOFF = 4'h7;
  localparam logic [3:0] CMD_PTR0   = 4'hB;

  typedef struct packed {
    logic [NUM_MR-1:0] mrWr;
    logic rxOn;
    logic rxOff;
    logic txOn;
    logic txOff;
    logic rxRst;
    logic txRst;
    logic errRst;
    logic brkChg;
    logic brkSet;
    logic brkClr;
  } ctlStrobe_t;
endpackage

// File: rtl/uart_chan_decode.sv
module uart_chan_decode
  import uart_chan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [BUS_W-1:0]     wrData,
  output ctlStrobe_t           strb,
  output modePtr_e             modePtr
);
  logic cmdWr, modeWr;
  logic [3:0] code;

  assign cmdWr  = wrEn && (regAddr == ADDR_CMD);
  assign modeWr = wrEn && (regAddr == ADDR_MODE);
  assign code   = wrData[7:4];

  always_comb begin
    strb        = '0;
    strb.mrWr[0] = modeWr && (modePtr == PTR_MR0);
    strb.mrWr[1] = modeWr && (modePtr == PTR_MR1);
    strb.mrWr[2] = modeWr && (modePtr == PTR_MR2);
    strb.rxOn   = cmdWr && wrData[0];
    strb.rxOff  = cmdWr && wrData[1];
    strb.txOn   = cmdWr && wrData[2];
    strb.txOff  = cmdWr && wrData[3];
    strb.rxRst  = cmdWr && (code == CMD_RXRST);
    strb.txRst  = cmdWr && (code == CMD_TXRST);
    strb.errRst = cmdWr && (code == CMD_ERRRST);
    strb.brkChg = cmdWr && (code == CMD_BRKCHG);
    strb.brkSet = cmdWr && (code == CMD_BRKON);
    strb.brkClr = cmdWr && (code == CMD_BRKOFF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePtr <= PTR_MR1;
    end else if (cmdWr && code == CMD_PTR1) begin
      modePtr <= PTR_MR1;
    end else if (cmdWr && code == CMD_PTR0) begin
      modePtr <= PTR_MR0;
    end else if (modeWr) begin
      unique case (modePtr)
        PTR_MR0: modePtr <= PTR_MR1;
        PTR_MR1: modePtr <= PTR_MR2;
        default: modePtr <= PTR_MR2;
      endcase
    end
  end
endmodule

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
  import uart_chan_pkg::*;
#(
  parameter logic [BUS_W-1:0] MR0_RST = 8'h00,
  parameter logic [BUS_W-1:0] MR1_RST = 8'h13,
  parameter logic [BUS_W-1:0] MR2_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [BUS_W-1:0]  wrData,
  input  modePtr_e          modePtr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rxReady,
  input  logic              rxFull,
  input  logic              txReady,
  input  logic              txEmpty,
  input  logic [3:0]        errEvt,
  output logic [BUS_W-1:0]  rdData,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              rxResetPulse,
  output logic              txResetPulse,
  output logic              brkChgClr,
  output logic              breakOn,
  output logic [3:0]        dataBits,
  output logic              parityOn,
  output logic              parityOdd,
  output logic              twoStop,
  output logic              fifoEn,
  output logic              txHalfLevel,
  output logic [2:0]        baudSet,
  output logic [BUS_W-1:0]  statusByte
);
  localparam logic [NUM_MR*BUS_W-1:0] RST_VEC = {MR2_RST, MR1_RST, MR0_RST};

  logic [BUS_W-1:0] mrReg [NUM_MR];
  logic [3:0]       errFlags;

  for (genvar i = 0; i < NUM_MR; i++) begin : g_mr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             mrReg[i] <= RST_VEC[i*BUS_W +: BUS_W];
      else if (strb.mrWr[i]) mrReg[i] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnable     <= 1'b0;
      txEnable     <= 1'b0;
      rxResetPulse <= 1'b0;
      txResetPulse <= 1'b0;
      brkChgClr    <= 1'b0;
      breakOn      <= 1'b0;
      errFlags     <= '0;
    end else begin
      if (strb.rxOff || strb.rxRst) rxEnable <= 1'b0;
      else if (strb.rxOn)           rxEnable <= 1'b1;
      if (strb.txOff || strb.txRst) txEnable <= 1'b0;
      else if (strb.txOn)           txEnable <= 1'b1;
      rxResetPulse <= strb.rxRst;
      txResetPulse <= strb.txRst;
      brkChgClr    <= strb.brkChg;
      if (strb.brkSet)      breakOn <= 1'b1;
      else if (strb.brkClr) breakOn <= 1'b0;
      if (strb.errRst) errFlags <= '0;
      else             errFlags <= errFlags | errEvt;
    end
  end

  assign statusByte  = {errFlags, txEmpty, txReady, rxFull, rxReady};
  assign dataBits    = 4'd5 + {2'b00, mrReg[1][1:0]};
  assign parityOn    = (mrReg[1][4:3] == 2'b00);
  assign parityOdd   = parityOn && mrReg[1][2];
  assign twoStop     = mrReg[2][3];
  assign fifoEn      = mrReg[0][3];
  assign txHalfLevel = mrReg[0][4];
  assign baudSet     = mrReg[0][2:0];

  always_comb begin
    unique case (regAddr)
      ADDR_MODE: rdData = mrReg[modePtr];
      ADDR_STAT: rdData = statusByte;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
  import uart_chan_pkg::*;
#(
  parameter logic [7:0] MR0_RST = 8'h00,
  parameter logic [7:0] MR1_RST = 8'h13,
  parameter logic [7:0] MR2_RST = 8'h07
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       rxReady,
  input  logic       rxFull,
  input  logic       txReady,
  input  logic       txEmpty,
  input  logic       ovrEvt,
  input  logic       parEvt,
  input  logic       frmEvt,
  input  logic       brkEvt,
  output logic       rxEnable,
  output logic       txEnable,
  output logic       rxResetPulse,
  output logic       txResetPulse,
  output logic       brkChgClr,
  output logic       breakOn,
  output logic [3:0] dataBits,
  output logic       parityOn,
  output logic       parityOdd,
  output logic       twoStop,
  output logic       fifoEn,
  output logic       txHalfLevel,
  output logic [2:0] baudSet,
  output logic [7:0] statusByte
);
  ctlStrobe_t strb;
  modePtr_e   modePtr;

  uart_chan_decode u_dec (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .strb(strb), .modePtr(modePtr)
  );

  uart_chan_regs #(.MR0_RST(MR0_RST), .MR1_RST(MR1_RST), .MR2_RST(MR2_RST)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .modePtr(modePtr), .regAddr(regAddr),
    .rxReady(rxReady), .rxFull(rxFull), .txReady(txReady), .txEmpty(txEmpty),
    .errEvt({brkEvt, frmEvt, parEvt, ovrEvt}),
    .rdData(rdData), .rxEnable(rxEnable), .txEnable(txEnable),
    .rxResetPulse(rxResetPulse), .txResetPulse(txResetPulse),
    .brkChgClr(brkChgClr), .breakOn(breakOn), .dataBits(dataBits),
    .parityOn(parityOn), .parityOdd(parityOdd), .twoStop(twoStop),
    .fifoEn(fifoEn), .txHalfLevel(txHalfLevel), .baudSet(baudSet),
    .statusByte(statusByte)
  );
endmodule

// File: rtl/uart_chan_ctrl_chk.sv
module uart_chan_ctrl_chk
  import uart_chan_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] regAddr,
  input logic [7:0] wrData,
  input logic       rxEnable,
  input logic       txEnable,
  input logic       rxResetPulse,
  input logic       breakOn,
  input logic [7:0] statusByte,
  input logic [3:0] dataBits,
  input logic       twoStop,
  input modePtr_e   modePtr
);
  logic cmdWr;
  assign cmdWr = wrEn && regAddr == ADDR_CMD;

  p_off_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && wrData[1] |=> !rxEnable);
  p_tx_off_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && wrData[3] |=> !txEnable);
  p_rx_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && wrData[1:0] == 2'b01 && wrData[7:4] != CMD_RXRST |=> rxEnable);
  p_ptr_cmd_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && wrData[7:4] == CMD_PTR1 |=> modePtr == PTR_MR1);
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && regAddr == ADDR_MODE && modePtr == PTR_MR2 |=> modePtr == PTR_MR2);
  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && wrData[7:4] == CMD_ERRRST |=> statusByte[7:4] == 4'h0);
  p_rx_reset_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && wrData[7:4] == CMD_RXRST |=> rxResetPulse && !rxEnable);
  p_break_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && wrData[7:4] == CMD_BRKON |=> breakOn);
  p_stat_write_r13: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && regAddr == ADDR_STAT |=> $stable(dataBits) && $stable(twoStop)
      && $stable(rxEnable) && $stable(txEnable));
endmodule

bind uart_chan_ctrl uart_chan_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .rxEnable(rxEnable), .txEnable(txEnable), .rxResetPulse(rxResetPulse),
  .breakOn(breakOn), .statusByte(statusByte), .dataBits(dataBits),
  .twoStop(twoStop), .modePtr(modePtr)
);

// File: tb/sim_uart_chan_ctrl.sv
`timescale 1ns/1ps
module sim_uart_chan_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic rxReady = 0, rxFull = 0, txReady = 0, txEmpty = 0;
  logic ovrEvt = 0, parEvt = 0, frmEvt = 0, brkEvt = 0;
  logic [7:0] rdData, statusByte;
  logic rxEnable, txEnable, rxResetPulse, txResetPulse, brkChgClr, breakOn;
  logic [3:0] dataBits;
  logic parityOn, parityOdd, twoStop, fifoEn, txHalfLevel;
  logic [2:0] baudSet;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_chan_ctrl u0 (.*);

  // {command byte, expected rxEnable, expected txEnable}
  localparam logic [9:0] VEC [10] = '{
    {8'h01, 1'b1, 1'b0}, {8'h04, 1'b1, 1'b1}, {8'h02, 1'b0, 1'b1},
    {8'h03, 1'b0, 1'b1}, {8'h0C, 1'b0, 1'b0}, {8'h05, 1'b1, 1'b1},
    {8'h21, 1'b0, 1'b1}, {8'h34, 1'b0, 1'b0}, {8'h05, 1'b1, 1'b1},
    {8'h0A, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enables", {rxEnable, txEnable}, 0);
    chk("R1 frame", {dataBits, parityOn, twoStop, fifoEn}, {4'd8, 3'b000});
    chk("R1 sticky", statusByte[7:4], 0);
    regAddr = 2'd0; #1;
    chk("R1 pointer reads mid reg", rdData, 8'h13);
    @(negedge clk);

    // R2 R3 R11 table walk
    foreach (VEC[i]) begin
      wr(2'd2, VEC[i][9:2]);
      chk($sformatf("R2/R3 vec%0d", i), {rxEnable, txEnable}, VEC[i][1:0]);
    end

    // R4 pointer to first, then advance; R8 R6 R7 R5
    wr(2'd2, 8'hB0);
    wr(2'd0, 8'h1D);
    chk("R8 fifo/half/baud", {fifoEn, txHalfLevel, baudSet}, {2'b11, 3'd5});
    wr(2'd0, 8'h06);
    chk("R6 7 bits odd", {dataBits, parityOn, parityOdd}, {4'd7, 2'b11});
    wr(2'd0, 8'h0F);
    chk("R7 two stop", twoStop, 1);
    wr(2'd0, 8'h07);
    chk("R5 stays on last reg", twoStop, 0);
    regAddr = 2'd0; #1;
    chk("R5 readback last", rdData, 8'h07);
    chk("R6 mid reg kept", dataBits, 7);
    @(negedge clk);
    wr(2'd2, 8'h10);
    regAddr = 2'd0; #1;
    chk("R4 ptr mid readback", rdData, 8'h06);
    @(negedge clk);
    wr(2'd0, 8'h00);
    chk("R6 5 bits even", {dataBits, parityOn, parityOdd}, {4'd5, 2'b10});
    wr(2'd2, 8'h10);
    wr(2'd0, 8'h13);
    chk("R6 8 bits none", {dataBits, parityOn}, {4'd8, 1'b0});

    // R9 status
    rxReady = 1; txEmpty = 1; #1;
    chk("R9 live bits", statusByte[3:0], 4'b1001);
    ovrEvt = 1; brkEvt = 1;
    @(negedge clk);
    ovrEvt = 0; brkEvt = 0;
    @(negedge clk);
    chk("R9 sticky held", statusByte[7:4], 4'b1001);
    regAddr = 2'd1; #1;
    chk("R13 status read", rdData, 8'h99);
    // R13 write to status ignored
    wr(2'd2, 8'h05);
    wr(2'd1, 8'hFF);
    chk("R13 status write ignored", {statusByte, dataBits, twoStop, rxEnable, txEnable},
        {8'h99, 4'd8, 1'b0, 2'b11});
    // R10 clear wins over event
    parEvt = 1;
    wr(2'd2, 8'h40);
    parEvt = 0;
    chk("R10 clear", statusByte[7:4], 0);

    // R11 reset strobes
    wr(2'd2, 8'h20);
    chk("R11 rx strobe", {rxResetPulse, rxEnable, txResetPulse}, 3'b100);
    @(negedge clk);
    chk("R11 rx strobe one cycle", rxResetPulse, 0);
    wr(2'd2, 8'h34);
    chk("R11 tx strobe", {txResetPulse, txEnable}, 2'b10);

    // R12 break
    wr(2'd2, 8'h60);
    chk("R12 break on", breakOn, 1);
    wr(2'd2, 8'h70);
    chk("R12 break off", breakOn, 0);
    wr(2'd2, 8'h50);
    chk("R12 chg strobe", brkChgClr, 1);
    @(negedge clk);
    chk("R12 chg strobe one cycle", brkChgClr, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule